// File: doc/BRIEF.md
# Coprocessor Feature Trap Controller

This block keeps the hypervisor's trap-control word and judges every access that a less privileged level makes to floating-point and SIMD hardware, trace system registers, activity-monitor registers or the lower access-control register. For each request it says, in the same cycle, whether the access goes to the hypervisor. It also says whether that happens as a hypervisor trap or as an undefined-instruction exception, and which exception class code goes with it.

Software writes the control word through a plain write port. A warm reset clears its functional bits. Three security flags from a higher-level access-control register force some fields to read as one while the core is in non-secure state. Those forced values are also the ones that drive the decision. A "trapped lower" input carries the verdict of the lower-level access-control logic, which has priority. When that input is set, this block stays silent.

The decision walks through three named outcomes. NONE applies when nothing fires. HYP_TRAP applies to a hit from non-secure EL0 or EL1. UNDEF_HYP applies to a hit taken in hypervisor mode (EL2). A request moves from NONE to a hit outcome only when its class is enabled and its level rules allow it.

Top module: `cp_trap_ctrl`

## Requirements
- R1: After a warm reset, the trap bits 31, 30, 20, 15, 11 and 10 read as zero, so with no override active the read value is 0x000033FF.
- R2: Bits 29:21, 19:16 and 14 always read 0 and ignore writes. Bits 13:12 and 9:0 always read 1. Bits 31, 30, 20, 15 and 10 hold the value last written to them.
- R3: Bit 11 has no storage of its own and always reads the same as bit 10, whatever was written to bit 11.
- R4: In non-secure state (non_secure=1), bit 20 reads one when sec_trace_off=1, bit 15 reads one when sec_simd_off=1, and bits 10 and 11 read one when sec_fp_en=0. In secure state the stored values are read unchanged. The trap decision always uses the values as read.
- R5: A request of kind 0 (FP/SIMD access) from non-secure EL0/EL1 traps with class 0x07 when the effective bit 10 is one.
- R6: A request of kind 1 (SIMD-only instruction) traps with class 0x07 when the effective bit 10 or the effective bit 15 is one. When bit 10 is one, the value of bit 15 does not matter.
- R7: A request of kind 2 (trace system register) traps when the effective bit 20 is one. The class is 0x05 for a single-register transfer (req_dual=0) and 0x0C for a two-register transfer (req_dual=1).
- R8: A request of kind 3 (activity monitor) traps only from EL0 or EL1 when bit 30 is one. The class is 0x03 for a single-register transfer and 0x04 for a two-register transfer.
- R9: A request of kind 4 (lower access-control register) traps only from EL1 when bit 31 is one, with class 0x03.
- R10: When lower_trap=1, no trap is reported.
- R11: A request traps under none of these conditions: req_valid=0, secure state, EL3, or a kind code of 5 to 7. Whenever no trap is reported, trap_undef and trap_class are both 0.
- R12: A hit taken at EL2 gives trap_valid=1, trap_undef=1 and trap_class=0x00. A hit taken at EL0 or EL1 gives trap_undef=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous warm reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control word as seen in the current security state |
| sec_trace_off | input | 1 | Higher-level override: trace trap forced on in non-secure state |
| sec_simd_off | input | 1 | Higher-level override: SIMD-only trap forced on in non-secure state |
| sec_fp_en | input | 1 | Higher-level enable for FP/SIMD; 0 forces the FP trap on in non-secure state |
| cur_el | input | 2 | Current exception level 0..3 |
| non_secure | input | 1 | 1 when the core is in non-secure state |
| req_valid | input | 1 | A request is present |
| req_kind | input | 3 | 0 FP/SIMD, 1 SIMD-only, 2 trace, 3 activity monitor, 4 access-control register |
| req_dual | input | 1 | 1 for a two-register transfer |
| lower_trap | input | 1 | The lower-level access-control logic already traps this access |
| trap_valid | output | 1 | The request is taken to the hypervisor |
| trap_undef | output | 1 | The request is taken as an undefined-instruction exception in hypervisor mode |
| trap_class | output | 6 | Exception class code, 0 when not trapped |

## Verification
The hardest case to reach is one where an override flag alone produces a trap while the stored bit is zero. Examples are a SIMD-only request trapped through sec_simd_off, or an FP request trapped through a cleared sec_fp_en. Such a case shows up only when non-secure state, an allowed level, a clear lower_trap and the right kind all coincide. Directed cases set these up explicitly, both in non-secure and in secure state. Random stimulus then draws flags, levels, kinds and write data independently, so that combinations of stored bits against override flags keep recurring.

// File: rtl/cptrap_pkg.sv
package cptrap_pkg;

    localparam int REG_W = 32;
    localparam int EC_W  = 6;

    localparam int POS_ACR  = 31;
    localparam int POS_AMON = 30;
    localparam int POS_TRC  = 20;
    localparam int POS_SIMD = 15;
    localparam int POS_FPX  = 11;
    localparam int POS_FP   = 10;

    localparam logic [REG_W-1:0] FIXED_ONES = 32'h0000_33FF;

    localparam logic [EC_W-1:0] EC_NONE   = 6'h00;
    localparam logic [EC_W-1:0] EC_SYS_1  = 6'h03;
    localparam logic [EC_W-1:0] EC_SYS_2  = 6'h04;
    localparam logic [EC_W-1:0] EC_TRC_1  = 6'h05;
    localparam logic [EC_W-1:0] EC_FPSIMD = 6'h07;
    localparam logic [EC_W-1:0] EC_TRC_2  = 6'h0C;

    typedef enum logic [2:0] {
        KIND_FP    = 3'd0,
        KIND_SIMD  = 3'd1,
        KIND_TRACE = 3'd2,
        KIND_AMON  = 3'd3,
        KIND_ACR   = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        OUT_NONE      = 2'd0,
        OUT_HYP_TRAP  = 2'd1,
        OUT_UNDEF_HYP = 2'd2
    } outcome_e;

    typedef struct packed {
        logic acr;
        logic amon;
        logic trc;
        logic simd;
        logic fp;
    } ctl_fields_t;

endpackage

// File: rtl/trapctl_store.sv
module trapctl_store
    import cptrap_pkg::*;
#(
    parameter bit AMON_PRESENT = 1'b1,
    parameter bit SIMD_RW      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             non_secure,
    input  logic             sec_trace_off,
    input  logic             sec_simd_off,
    input  logic             sec_fp_en,
    output logic [REG_W-1:0] rd_data,
    output ctl_fields_t      eff
);

    logic r_acr, r_amon, r_trc, r_simd, r_fp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_acr <= 1'b0;
            r_trc <= 1'b0;
            r_fp  <= 1'b0;
        end else if (wr_en) begin
            r_acr <= wr_data[POS_ACR];
            r_trc <= wr_data[POS_TRC];
            r_fp  <= wr_data[POS_FP];
        end
    end

    generate
        if (AMON_PRESENT) begin : g_amon
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     r_amon <= 1'b0;
                else if (wr_en) r_amon <= wr_data[POS_AMON];
            end
        end else begin : g_no_amon
            assign r_amon = 1'b0;
        end

        if (SIMD_RW) begin : g_simd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     r_simd <= 1'b0;
                else if (wr_en) r_simd <= wr_data[POS_SIMD];
            end
        end else begin : g_no_simd
            assign r_simd = 1'b0;
        end
    endgenerate

    // Forced views apply only in non-secure state
    always_comb begin
        eff.acr  = r_acr;
        eff.amon = r_amon;
        eff.trc  = r_trc  | (non_secure & sec_trace_off);
        eff.simd = r_simd | (non_secure & sec_simd_off);
        eff.fp   = r_fp   | (non_secure & ~sec_fp_en);
    end

    always_comb begin
        rd_data           = FIXED_ONES;
        rd_data[POS_ACR]  = eff.acr;
        rd_data[POS_AMON] = eff.amon;
        rd_data[POS_TRC]  = eff.trc;
        rd_data[POS_SIMD] = eff.simd;
        rd_data[POS_FPX]  = eff.fp;
        rd_data[POS_FP]   = eff.fp;
    end

    // R2: stored trap bits change only on a write
    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({r_acr, r_amon, r_trc, r_simd, r_fp}));

endmodule

// File: rtl/trapctl_decide.sv
module trapctl_decide
    import cptrap_pkg::*;
(
    input  ctl_fields_t     eff,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic            req_dual,
    input  logic [1:0]      cur_el,
    input  logic            non_secure,
    input  logic            lower_trap,
    output logic            trap_valid,
    output logic            trap_undef,
    output logic [EC_W-1:0] trap_class
);

    logic            hit;
    logic [EC_W-1:0] ec;
    logic            el_low;
    outcome_e        outcome;

    assign el_low = (cur_el == 2'd0) || (cur_el == 2'd1);

    always_comb begin
        hit = 1'b0;
        ec  = EC_NONE;
        unique case (req_kind_e'(req_kind))
            KIND_FP: begin
                hit = eff.fp;
                ec  = EC_FPSIMD;
            end
            KIND_SIMD: begin
                hit = eff.fp | eff.simd;
                ec  = EC_FPSIMD;
            end
            KIND_TRACE: begin
                hit = eff.trc;
                ec  = req_dual ? EC_TRC_2 : EC_TRC_1;
            end
            KIND_AMON: begin
                hit = eff.amon & el_low;
                ec  = req_dual ? EC_SYS_2 : EC_SYS_1;
            end
            KIND_ACR: begin
                hit = eff.acr & (cur_el == 2'd1);
                ec  = EC_SYS_1;
            end
            default: begin
                hit = 1'b0;
                ec  = EC_NONE;
            end
        endcase
        if (!req_valid || !non_secure || lower_trap || cur_el == 2'd3)
            hit = 1'b0;
    end

    always_comb begin
        if (!hit)                outcome = OUT_NONE;
        else if (cur_el == 2'd2) outcome = OUT_UNDEF_HYP;
        else                     outcome = OUT_HYP_TRAP;
    end

    always_comb begin
        unique case (outcome)
            OUT_HYP_TRAP: begin
                trap_valid = 1'b1;
                trap_undef = 1'b0;
                trap_class = ec;
            end
            OUT_UNDEF_HYP: begin
                trap_valid = 1'b1;
                trap_undef = 1'b1;
                trap_class = EC_NONE;
            end
            default: begin
                trap_valid = 1'b0;
                trap_undef = 1'b0;
                trap_class = EC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/cp_trap_ctrl.sv
module cp_trap_ctrl
    import cptrap_pkg::*;
#(
    parameter bit AMON_PRESENT = 1'b1,
    parameter bit SIMD_RW      = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        sec_trace_off,
    input  logic        sec_simd_off,
    input  logic        sec_fp_en,
    input  logic [1:0]  cur_el,
    input  logic        non_secure,
    input  logic        req_valid,
    input  logic [2:0]  req_kind,
    input  logic        req_dual,
    input  logic        lower_trap,
    output logic        trap_valid,
    output logic        trap_undef,
    output logic [5:0]  trap_class
);

    ctl_fields_t eff;

    trapctl_store #(
        .AMON_PRESENT (AMON_PRESENT),
        .SIMD_RW      (SIMD_RW)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .non_secure    (non_secure),
        .sec_trace_off (sec_trace_off),
        .sec_simd_off  (sec_simd_off),
        .sec_fp_en     (sec_fp_en),
        .rd_data       (rd_data),
        .eff           (eff)
    );

    trapctl_decide u_decide (
        .eff        (eff),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_dual   (req_dual),
        .cur_el     (cur_el),
        .non_secure (non_secure),
        .lower_trap (lower_trap),
        .trap_valid (trap_valid),
        .trap_undef (trap_undef),
        .trap_class (trap_class)
    );

    a_r4_fp_forced_ns: assert property (@(posedge clk) disable iff (!rst_n)
        (non_secure && !sec_fp_en) |-> (rd_data[POS_FP] && rd_data[POS_FPX]));

    a_r5_fp_class: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_undef && req_kind == 3'd0) |-> trap_class == EC_FPSIMD);

    a_r9_acr_el1_only: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && req_kind == 3'd4) |-> cur_el == 2'd1);

    a_r10_lower_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lower_trap |-> !trap_valid);

    a_r11_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (!trap_undef && trap_class == EC_NONE));

    a_r12_hyp_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_el == 2'd2) |-> (trap_undef && trap_class == EC_NONE));

endmodule

// File: tb/tb_cp_trap_ctrl.sv
`timescale 1ns/1ps
module tb_cp_trap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sec_trace_off = 1'b0, sec_simd_off = 1'b0, sec_fp_en = 1'b1;
    logic [1:0]  cur_el = 2'd1;
    logic        non_secure = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic        req_dual = 1'b0;
    logic        lower_trap = 1'b0;
    logic        trap_valid, trap_undef;
    logic [5:0]  trap_class;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench shadow of the stored trap bits
    bit m_acr, m_amon, m_trc, m_simd, m_fp;

    always #5 clk = ~clk;

    cp_trap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sec_trace_off(sec_trace_off), .sec_simd_off(sec_simd_off), .sec_fp_en(sec_fp_en),
        .cur_el(cur_el), .non_secure(non_secure), .req_valid(req_valid), .req_kind(req_kind),
        .req_dual(req_dual), .lower_trap(lower_trap),
        .trap_valid(trap_valid), .trap_undef(trap_undef), .trap_class(trap_class)
    );

    function automatic logic [31:0] exp_read();
        logic [31:0] v;
        bit f10, f15, f20;
        f10 = m_fp   | (non_secure & ~sec_fp_en);
        f15 = m_simd | (non_secure & sec_simd_off);
        f20 = m_trc  | (non_secure & sec_trace_off);
        v = 32'h0000_33FF;
        v[31] = m_acr; v[30] = m_amon; v[20] = f20; v[15] = f15; v[11] = f10; v[10] = f10;
        return v;
    endfunction

    function automatic logic [7:0] exp_trap();
        bit hit;
        logic [5:0] ec;
        bit f10, f15, f20;
        f10 = m_fp   | ~sec_fp_en;
        f15 = m_simd | sec_simd_off;
        f20 = m_trc  | sec_trace_off;
        hit = 1'b0; ec = 6'h00;
        case (req_kind)
            3'd0: begin hit = f10;        ec = 6'h07; end
            3'd1: begin hit = f10 | f15;  ec = 6'h07; end
            3'd2: begin hit = f20;        ec = req_dual ? 6'h0C : 6'h05; end
            3'd3: begin hit = m_amon && cur_el <= 2'd1; ec = req_dual ? 6'h04 : 6'h03; end
            3'd4: begin hit = m_acr && cur_el == 2'd1;  ec = 6'h03; end
            default: hit = 1'b0;
        endcase
        if (!req_valid || !non_secure || lower_trap || cur_el == 2'd3) hit = 1'b0;
        if (!hit) return 8'h00;
        if (cur_el == 2'd2) return {1'b1, 1'b1, 6'h00};
        return {1'b1, 1'b0, ec};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_acr = d[31]; m_amon = d[30]; m_trc = d[20]; m_simd = d[15]; m_fp = d[10];
    endtask

    task automatic rq(input logic [2:0] k, input logic dual, input logic [1:0] el,
                      input logic ns, input logic low);
        req_valid = 1'b1; req_kind = k; req_dual = dual; cur_el = el;
        non_secure = ns; lower_trap = low;
        #1;
    endtask

    function automatic logic [31:0] trap_word();
        return {24'h0, trap_valid, trap_undef, trap_class};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        chk("R1 reset read", rd_data, 32'h0000_33FF);
        // R2 masking
        wr(32'hFFFF_FFFF);
        chk("R2 all ones", rd_data, exp_read());
        chk("R2 all ones literal", rd_data, 32'hC010_BFFF);
        wr(32'h0000_0000);
        chk("R2 all zeros", rd_data, 32'h0000_33FF);
        // R3 bit11 follows bit10
        wr(32'h0000_0800);
        chk("R3 bit11 alone", rd_data, 32'h0000_33FF);
        wr(32'h0000_0400);
        chk("R3 bit10 alone", rd_data, 32'h0000_3FFF);
        // R4 forced reads
        wr(32'h0);
        sec_trace_off = 1; sec_simd_off = 1; sec_fp_en = 0; non_secure = 1; #1;
        chk("R4 forced ns", rd_data, 32'h0010_BFFF);
        non_secure = 0; #1;
        chk("R4 secure raw", rd_data, 32'h0000_33FF);
        // R4 override alone traps
        rq(3'd1, 0, 2'd0, 1, 0);
        chk("R4 simd trap via overrides", trap_word(), 32'h87);
        rq(3'd1, 0, 2'd0, 0, 0);
        chk("R11 secure no trap", trap_word(), 32'h00);
        sec_trace_off = 0; sec_simd_off = 0; sec_fp_en = 1;
        // R5 / R6
        wr(32'h0000_0400);
        rq(3'd0, 0, 2'd1, 1, 0);
        chk("R5 fp trap", trap_word(), 32'h87);
        rq(3'd1, 0, 2'd0, 1, 0);
        chk("R6 simd via fp bit", trap_word(), 32'h87);
        wr(32'h0000_8000);
        rq(3'd1, 0, 2'd1, 1, 0);
        chk("R6 simd bit alone", trap_word(), 32'h87);
        rq(3'd0, 0, 2'd1, 1, 0);
        chk("R6 simd bit no fp effect", trap_word(), 32'h00);
        // R7 trace
        wr(32'h0010_0000);
        rq(3'd2, 0, 2'd0, 1, 0);
        chk("R7 trace single", trap_word(), 32'h85);
        rq(3'd2, 1, 2'd1, 1, 0);
        chk("R7 trace dual", trap_word(), 32'h8C);
        // R12 hyp undef
        rq(3'd2, 1, 2'd2, 1, 0);
        chk("R12 trace at el2", trap_word(), 32'hC0);
        // R10 lower wins
        rq(3'd2, 0, 2'd1, 1, 1);
        chk("R10 lower trap", trap_word(), 32'h00);
        // R8 amon
        wr(32'h4000_0000);
        rq(3'd3, 1, 2'd0, 1, 0);
        chk("R8 amon dual el0", trap_word(), 32'h84);
        rq(3'd3, 0, 2'd1, 1, 0);
        chk("R8 amon single el1", trap_word(), 32'h83);
        rq(3'd3, 0, 2'd2, 1, 0);
        chk("R8 amon el2 none", trap_word(), 32'h00);
        // R9 acr
        wr(32'h8000_0000);
        rq(3'd4, 0, 2'd1, 1, 0);
        chk("R9 acr el1", trap_word(), 32'h83);
        rq(3'd4, 0, 2'd0, 1, 0);
        chk("R9 acr el0 none", trap_word(), 32'h00);
        // R11 el3, reserved kind, no valid
        wr(32'hFFFF_FFFF);
        rq(3'd0, 0, 2'd3, 1, 0);
        chk("R11 el3 none", trap_word(), 32'h00);
        rq(3'd6, 0, 2'd1, 1, 0);
        chk("R11 reserved kind", trap_word(), 32'h00);
        req_valid = 0; req_kind = 3'd0; #1;
        chk("R11 no valid", trap_word(), 32'h00);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0)
                wr(($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF : $urandom());
            @(negedge clk);
            sec_trace_off = ($urandom_range(0, 3) == 0);
            sec_simd_off  = ($urandom_range(0, 3) == 0);
            sec_fp_en     = ($urandom_range(0, 3) != 0);
            req_valid     = ($urandom_range(0, 7) != 0);
            req_kind      = 3'($urandom_range(0, 5));
            req_dual      = 1'($urandom_range(0, 1));
            cur_el        = 2'($urandom_range(0, 3));
            non_secure    = ($urandom_range(0, 4) != 0);
            lower_trap    = ($urandom_range(0, 5) == 0);
            #1;
            chk("R2/R3/R4 random read", rd_data, exp_read());
            chk("R5-R12 random trap", trap_word(), {24'h0, exp_trap()});
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule